// File: doc/BRIEF.md
# Three-Stage Power Rail Bring-Up Sequencer

This block is a synchronous controller that switches on the rails of a multi-rail power system in three dependent stages and then supervises them. Stage one runs directly from the input supply, stage two is fed from stage one, and stage three is fed from stage two. The controller drives a 10-bit enable word. Each bit may switch several rails that share one output. Each input is a digitised window-good flag, meaning its rail sits inside a ±5 % band around nominal. A separate flag reports that the input supply is good.

Bring-up works through a fixed chain of states. The controller first waits for the input supply to be good for a full dwell time. It then enables stage one, waits, and judges it, and does the same for stages two and three. If a stage fails its judgement during bring-up, only that stage is switched off and the stage below it is judged again before the retry. The number of failures per stage is capped, and the next failure past the cap parks the machine in a lockout state that only reset leaves. Once all three stages pass, the controller stays in a run state. Any fault there switches everything off and restarts from the input check.

The state names are WAIT, UP1, CHK1, UP2, CHK2, DN2, UP3, CHK3, DN3, RUN and LOCK. The transitions are:
- WAIT to UP1 when the input is stable.
- UPk to CHKk when the dwell ends.
- CHKk to UP(k+1) on a pass, and CHK3 to RUN on a pass.
- CHK1 to WAIT, CHK2 to DN2 and CHK3 to DN3 on a fail.
- DN2 to CHK1 and DN3 to CHK2 when the dwell ends.
- RUN to WAIT on a fault.
- Any CHK state to LOCK when that stage fails beyond its cap.

Top module: `rail_sequencer`

## Requirements
- R1: A synchronous active-high `rst` forces state WAIT, `rail_en` = 0 and `lockout` = 0, and clears all retry counters.
- R2: WAIT moves to UP1 only after `vin_good` has been 1 for PWR_TICKS consecutive clocks. Any clock with `vin_good` = 0 restarts that count.
- R3: `rail_en` (bit 9 is the highest) is 0 in WAIT and LOCK. It is 10'b11010_00001 in UP1, CHK1 and DN2. It is 10'b11111_10111 in UP2, CHK2 and DN3. It is 10'b11111_11111 in UP3, CHK3 and RUN.
- R4: Each UP and DN state lasts exactly DWELL_TICKS clocks. After that, UPk goes to CHKk, DN2 goes to CHK1 and DN3 goes to CHK2.
- R5: Each CHK state lasts one clock. If stage k is good, CHK1 goes to UP2, CHK2 goes to UP3 and CHK3 goes to RUN. If stage k is not good, CHK1 goes to WAIT, CHK2 goes to DN2 and CHK3 goes to DN3.
- R6: RUN is held while `vin_good` is 1 and all three stages are good. Otherwise the next clock is WAIT with `rail_en` = 0.
- R7: Each stage has its own failure counter. A failed judgement increments it while it is below MAX_RETRY. A failed judgement with the counter at MAX_RETRY enters LOCK, where `state_code` = 15, `lockout` = 1 and `rail_en` = 0, and LOCK is held until reset. The counters clear while in RUN.
- R8: A stage is good when every `rail_good` bit in its mask is 1, and bits outside the mask have no effect. The default masks are stage 1 = bits 3:0, stage 2 = bits 9:4 and stage 3 = bits 11:10.
- R9: `state_code` encodes the states as WAIT=0, UP1=1, CHK1=2, UP2=3, CHK2=4, DN2=5, UP3=6, CHK3=7, DN3=8, RUN=9 and LOCK=15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_good | input | 1 | Input supply within its window |
| rail_good | input | NG (12) | Per-group window-good flags, already synchronised |
| rail_en | output | 10 | Stage enable word |
| state_code | output | 4 | Current state encoding |
| lockout | output | 1 | Retry cap exceeded, held until reset |

## Verification
Two functions can act on the same check cycle: the rollback of a failed stage and the retry cap that turns that same failure into lockout. The bench drives repeated stage-one failures from reset so that the third failed judgement lands exactly on the cap. It expects WAIT after the first two failures and LOCK after the third. A second overlap occurs when a reset arrives in the same cycle as a run fault or a check judgement. Random resets and random single-bit faults mixed into long runs provoke this overlap. Every cycle is compared against a reference model in the bench that is built from the requirements.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [3:0] {
        ST_WAIT = 4'd0,
        ST_UP1  = 4'd1,
        ST_CHK1 = 4'd2,
        ST_UP2  = 4'd3,
        ST_CHK2 = 4'd4,
        ST_DN2  = 4'd5,
        ST_UP3  = 4'd6,
        ST_CHK3 = 4'd7,
        ST_DN3  = 4'd8,
        ST_RUN  = 4'd9,
        ST_LOCK = 4'd15
    } seq_state_e;

    localparam int NUM_STAGES = 3;
    localparam int EN_W       = 10;

endpackage

// File: rtl/seq_dwell_timer.sv
module seq_dwell_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Counts clocks since the last restart, saturating at all ones.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != {CW{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == (limit - 1'b1));

endmodule

// File: rtl/seq_stage_judge.sv
module seq_stage_judge #(
    parameter int                 NG    = 12,
    parameter int                 NS    = 3,
    parameter logic [NS*NG-1:0]   MASKS = '0
) (
    input  logic [NG-1:0] good,
    output logic [NS-1:0] stage_ok
);

    for (genvar s = 0; s < NS; s++) begin : g_stage
        // Bits outside the mask are forced to 1 before the reduction.
        assign stage_ok[s] = &(good | ~MASKS[s*NG +: NG]);
    end

endmodule

// File: rtl/seq_retry_bank.sv
module seq_retry_bank #(
    parameter int unsigned MAXR = 3,
    parameter int unsigned NS   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [NS-1:0] bump,
    output logic [NS-1:0] at_cap
);

    localparam int unsigned RW = $clog2(MAXR + 2);

    for (genvar s = 0; s < NS; s++) begin : g_cnt
        logic [RW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                cnt_q <= '0;
            end else if (bump[s] && (cnt_q != RW'(MAXR))) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        assign at_cap[s] = (cnt_q == RW'(MAXR));

        AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
            bump[s] |=> (cnt_q <= RW'(MAXR))); // R7
    end

endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned    NG          = 12,
    parameter int unsigned    PWR_TICKS   = 12_500_000,
    parameter int unsigned    DWELL_TICKS = 12_500_000,
    parameter int unsigned    MAX_RETRY   = 3,
    parameter logic [NG-1:0]  MASK_S1     = 12'h00F,
    parameter logic [NG-1:0]  MASK_S2     = 12'h3F0,
    parameter logic [NG-1:0]  MASK_S3     = 12'hC00,
    parameter logic [9:0]     EN_S1       = 10'b11010_00001,
    parameter logic [9:0]     EN_S12      = 10'b11111_10111,
    parameter logic [9:0]     EN_ALL      = 10'b11111_11111
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vin_good,
    input  logic [NG-1:0] rail_good,
    output logic [9:0]    rail_en,
    output logic [3:0]    state_code,
    output logic          lockout
);

    localparam int unsigned LMAX = (PWR_TICKS > DWELL_TICKS) ? PWR_TICKS : DWELL_TICKS;
    localparam int unsigned TW   = $clog2(LMAX + 1);

    seq_state_e            state_q, state_d;
    logic [NUM_STAGES-1:0] stage_ok;
    logic [NUM_STAGES-1:0] at_cap;
    logic [NUM_STAGES-1:0] bump;
    logic                  tmr_done;
    logic                  tmr_restart;
    logic [TW-1:0]         tmr_limit;
    logic                  all_ok;

    seq_stage_judge #(
        .NG    (NG),
        .NS    (NUM_STAGES),
        .MASKS ({MASK_S3, MASK_S2, MASK_S1})
    ) i_judge (
        .good     (rail_good),
        .stage_ok (stage_ok)
    );

    seq_retry_bank #(
        .MAXR (MAX_RETRY),
        .NS   (NUM_STAGES)
    ) i_retry (
        .clk    (clk),
        .rst    (rst),
        .clr    (state_q == ST_RUN),
        .bump   (bump),
        .at_cap (at_cap)
    );

    assign tmr_limit   = (state_q == ST_WAIT) ? TW'(PWR_TICKS) : TW'(DWELL_TICKS);
    assign tmr_restart = (state_d != state_q) || ((state_q == ST_WAIT) && !vin_good);

    seq_dwell_timer #(
        .CW (TW)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .limit   (tmr_limit),
        .done    (tmr_done)
    );

    assign all_ok = vin_good && (&stage_ok);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        bump    = '0;
        unique case (state_q)
            ST_WAIT: if (vin_good && tmr_done) state_d = ST_UP1;
            ST_UP1:  if (tmr_done) state_d = ST_CHK1;
            ST_CHK1: begin
                if (stage_ok[0]) begin
                    state_d = ST_UP2;
                end else if (at_cap[0]) begin
                    state_d = ST_LOCK;
                end else begin
                    bump[0] = 1'b1;
                    state_d = ST_WAIT;
                end
            end
            ST_UP2:  if (tmr_done) state_d = ST_CHK2;
            ST_CHK2: begin
                if (stage_ok[1]) begin
                    state_d = ST_UP3;
                end else if (at_cap[1]) begin
                    state_d = ST_LOCK;
                end else begin
                    bump[1] = 1'b1;
                    state_d = ST_DN2;
                end
            end
            ST_DN2:  if (tmr_done) state_d = ST_CHK1;
            ST_UP3:  if (tmr_done) state_d = ST_CHK3;
            ST_CHK3: begin
                if (stage_ok[2]) begin
                    state_d = ST_RUN;
                end else if (at_cap[2]) begin
                    state_d = ST_LOCK;
                end else begin
                    bump[2] = 1'b1;
                    state_d = ST_DN3;
                end
            end
            ST_DN3:  if (tmr_done) state_d = ST_CHK2;
            ST_RUN:  if (!all_ok) state_d = ST_WAIT;
            ST_LOCK: state_d = ST_LOCK;
            default: state_d = ST_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        rail_en = '0;
        unique case (state_q)
            ST_UP1, ST_CHK1, ST_DN2: rail_en = EN_S1;
            ST_UP2, ST_CHK2, ST_DN3: rail_en = EN_S12;
            ST_UP3, ST_CHK3, ST_RUN: rail_en = EN_ALL;
            default:                 rail_en = '0;
        endcase
    end

    assign state_code = state_q;
    assign lockout    = (state_q == ST_LOCK);

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !vin_good) |=> (state_q == ST_WAIT)); // R2

    AST_UP_DWELL: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_UP1 || state_q == ST_UP2 || state_q == ST_UP3) && !tmr_done)
        |=> $stable(rail_en)); // R4

    AST_CHK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHK1 || state_q == ST_CHK2 || state_q == ST_CHK3)
        |=> (state_q != $past(state_q))); // R5

    AST_RUN_FAULT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !(vin_good && (&stage_ok))) |=> (rail_en == '0)); // R6

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LOCK) |=> (lockout && rail_en == '0)); // R7

endmodule

// File: tb/test_rail_sequencer.sv
module test_rail_sequencer;

    localparam int PWR = 8;
    localparam int DW  = 5;
    localparam int MXR = 2;
    localparam logic [11:0] M1 = 12'h00F;
    localparam logic [11:0] M2 = 12'h3F0;
    localparam logic [11:0] M3 = 12'hC00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vin_good = 1'b0;
    logic [11:0] rail_good = '0;
    logic [9:0]  rail_en;
    logic [3:0]  state_code;
    logic        lockout;

    int total = 0;
    int bad   = 0;
    bit fin   = 1'b0;

    // reference model state
    int m_st  = 0;
    int m_cnt = 0;
    int m_rt [3];

    always #4 clk = ~clk;

    rail_sequencer #(
        .NG          (12),
        .PWR_TICKS   (PWR),
        .DWELL_TICKS (DW),
        .MAX_RETRY   (MXR)
    ) i_rail_sequencer (
        .clk        (clk),
        .rst        (rst),
        .vin_good   (vin_good),
        .rail_good  (rail_good),
        .rail_en    (rail_en),
        .state_code (state_code),
        .lockout    (lockout)
    );

    function automatic logic [9:0] exp_en(int st);
        case (st)
            1, 2, 5: return 10'b11010_00001;
            3, 4, 8: return 10'b11111_10111;
            6, 7, 9: return 10'b11111_11111;
            default: return 10'b0;
        endcase
    endfunction

    function automatic bit ok_of(logic [11:0] g, logic [11:0] m);
        return &(g | ~m);
    endfunction

    task automatic model_step(input bit r, input bit vg, input logic [11:0] g);
        int nx;
        bit ok [3];
        ok[0] = ok_of(g, M1);
        ok[1] = ok_of(g, M2);
        ok[2] = ok_of(g, M3);
        nx = m_st;
        if (r) begin
            m_st = 0; m_cnt = 0;
            for (int i = 0; i < 3; i++) m_rt[i] = 0;
            return;
        end
        case (m_st)
            0: if (vg && m_cnt == PWR - 1) nx = 1;
            1: if (m_cnt == DW - 1) nx = 2;
            3: if (m_cnt == DW - 1) nx = 4;
            6: if (m_cnt == DW - 1) nx = 7;
            5: if (m_cnt == DW - 1) nx = 2;
            8: if (m_cnt == DW - 1) nx = 4;
            2, 4, 7: begin
                int k;
                k = (m_st == 2) ? 0 : (m_st == 4) ? 1 : 2;
                if (ok[k]) nx = (k == 0) ? 3 : (k == 1) ? 6 : 9;
                else if (m_rt[k] == MXR) nx = 15;
                else begin
                    m_rt[k]++;
                    nx = (k == 0) ? 0 : (k == 1) ? 5 : 8;
                end
            end
            9: if (!(vg && ok[0] && ok[1] && ok[2])) nx = 0;
            default: nx = 15;
        endcase
        if (m_st == 9) for (int i = 0; i < 3; i++) m_rt[i] = 0;
        if (nx != m_st || (m_st == 0 && !vg)) m_cnt = 0;
        else if (m_cnt < 1_000_000) m_cnt++;
        m_st = nx;
    endtask

    // one clock: drive, advance model, compare at the falling edge
    task automatic step(input bit r, input bit vg, input logic [11:0] g);
        rst = r; vin_good = vg; rail_good = g;
        model_step(r, vg, g);
        @(negedge clk);
        total++;
        if (state_code !== 4'(m_st) || rail_en !== exp_en(m_st) || lockout !== (m_st == 15)) begin
            bad++;
            $display("FAIL R3 R9 model: state=%0d en=%b lock=%b expected state=%0d en=%b lock=%b",
                     state_code, rail_en, lockout, m_st, exp_en(m_st), m_st == 15);
        end
    endtask

    task automatic spot(input logic [3:0] code, input logic [9:0] en, input string req);
        total++;
        if (state_code !== code || rail_en !== en) begin
            bad++;
            $display("FAIL %s: state=%0d en=%b expected state=%0d en=%b", req, state_code, rail_en, code, en);
        end
    endtask

    task automatic run(input int n, input bit vg, input logic [11:0] g);
        for (int i = 0; i < n; i++) step(1'b0, vg, g);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd1357);
        @(negedge clk);
        step(1'b1, 1'b0, '0);
        step(1'b1, 1'b0, '0);
        spot(4'd0, 10'b0, "R1");
        total++;
        if (lockout !== 1'b0) begin bad++; $display("FAIL R1: lockout=%b expected 0", lockout); end

        // R2: stable input wait with a restart
        run(PWR - 1, 1'b1, 12'hFFF);
        spot(4'd0, 10'b0, "R2");
        run(1, 1'b0, 12'hFFF);
        run(PWR - 1, 1'b1, 12'h00F);
        spot(4'd0, 10'b0, "R2");
        run(1, 1'b1, 12'h00F);
        spot(4'd1, 10'b11010_00001, "R2");
        // R4: dwell of UP1
        run(DW - 1, 1'b1, 12'h00F);
        spot(4'd1, 10'b11010_00001, "R4");
        run(1, 1'b1, 12'h00F);
        spot(4'd2, 10'b11010_00001, "R4");
        // R8: only stage-1 bits set, unmasked zeros ignored
        run(1, 1'b1, 12'h00F);
        spot(4'd3, 10'b11111_10111, "R8");
        run(DW, 1'b1, 12'h00F);
        spot(4'd4, 10'b11111_10111, "R4");
        // R5: stage 2 fails, roll back
        run(1, 1'b1, 12'h00F);
        spot(4'd5, 10'b11010_00001, "R5");
        run(DW, 1'b1, 12'hFFF);
        spot(4'd2, 10'b11010_00001, "R4");
        run(1, 1'b1, 12'hFFF);
        run(DW, 1'b1, 12'hFFF);
        run(1, 1'b1, 12'hFFF);
        spot(4'd6, 10'b11111_11111, "R3");
        run(DW, 1'b1, 12'hFFF);
        run(1, 1'b1, 12'hFFF);
        spot(4'd9, 10'b11111_11111, "R5");
        run(10, 1'b1, 12'hFFF);
        spot(4'd9, 10'b11111_11111, "R6");
        run(1, 1'b1, 12'h7FF);
        spot(4'd0, 10'b0, "R6");

        // R7: three stage-1 failures with cap 2
        step(1'b1, 1'b0, '0);
        for (int k = 0; k < 2; k++) begin
            run(PWR + DW + 1, 1'b1, 12'h000);
            spot(4'd0, 10'b0, "R7");
        end
        run(PWR + DW + 1, 1'b1, 12'h000);
        spot(4'd15, 10'b0, "R7");
        run(20, 1'b1, 12'hFFF);
        spot(4'd15, 10'b0, "R7");
        total++;
        if (lockout !== 1'b1) begin bad++; $display("FAIL R7: lockout=%b expected 1", lockout); end
        step(1'b1, 1'b1, 12'hFFF);
        spot(4'd0, 10'b0, "R1");

        // random phase against the model
        for (int i = 0; i < 6000; i++) begin
            bit r, vg;
            logic [11:0] g;
            r  = ($urandom % 500) == 0;
            vg = ($urandom % 80) != 0;
            g  = 12'hFFF;
            if (($urandom % 25) == 0) g = g & ~(12'h1 << ($urandom % 12));
            step(r, vg, g);
        end

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule